// File: doc/BRIEF.md
# Direct-Delivery Interrupt Pending Controller

This block collects a set of wired interrupt sources for one interrupt domain that delivers straight to a single hart. Each source has a mode that says whether it is off, detached, edge-sensitive (rising or falling) or level-sensitive (active high or active low). The raw wire is rectified according to that mode. The block then keeps a pending bit and an enable bit per source. It presents the most urgent source that is both pending and enabled as a top-interrupt word, and it drives one interrupt line toward the hart.

For a level-sensitive source the pending bit is never latched. It is reloaded from the rectified wire on every clock. Masking a source therefore cannot leave a stale pending bit behind, and unmasking it later shows the source only while its wire is still asserted. Edge-sensitive sources latch a pending bit on a rectified rising edge. A claim read or an explicit clear-pending write removes that bit.

Software-facing strobes arrive as valid-plus-source-number pairs: set enable, clear enable and clear pending. A claim strobe marks the cycle in which the claim word is read. The claim word always equals the top-interrupt word. Mode and priority per source are static configuration inputs.

Top module: `dd_irq_ctrl`

## Requirements
- R1: The mode of each source is a 3-bit code. The codes are 0 off, 1 detached, 4 rising edge, 5 falling edge, 6 level high and 7 level low. Codes 2 and 3 behave as off. Source k uses bits [3k-1:3k-3] of the mode vector, and its raw wire is bit k-1. For modes 6 and 7, the pending bit after every rising clock edge equals the rectified value of the wire sampled at that edge. The rectified value is the wire itself for mode 6 and its inverse for mode 7.
- R2: Masking a level source does not freeze its pending bit. If the wire drops while the source is masked and the source is then unmasked, the top-interrupt word stays 0 for that source. If the wire is active when the source is unmasked, the source appears.
- R3: A set-enable strobe with source number k sets the enable of k, and a clear-enable strobe with k clears it. The change is visible after that clock edge. When both strobes name the same source in the same cycle, the clear wins.
- R4: The top-interrupt word carries the source number in bits [25:16] and the priority in bits [7:0]. All other bits are 0. It reads 0 when no source is both pending and enabled. Among the candidates, the smallest priority value wins. Ties go to the smallest source number. Source k's priority is bits [8k-1:8k-8] of the priority vector.
- R5: The claim output always equals the top-interrupt word. A claim strobe clears the pending bit of the source named in the top-interrupt word if that source is edge-sensitive. It has no effect on a level-sensitive source.
- R6: In modes 4 and 5, a rectified rising edge sets pending. Mode 5 rectifies by inversion, so a falling wire counts as the edge. Pending then holds until a claim or a clear-pending strobe for that source. A clear-pending strobe for a level source has no effect. A new edge in the same cycle as a clear wins over the clear.
- R7: Sources in the off or detached modes keep pending and enable at 0, and strobes naming them have no effect. Strobes naming source 0, or a number above the source count, change nothing.
- R8: The interrupt output is high exactly when the domain enable input is high and the top-interrupt word is non-zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| src_raw_i | input | NUM_SRC | Raw source wires, bit k-1 is source k |
| src_mode_i | input | 3*NUM_SRC | Mode code per source |
| src_prio_i | input | 8*NUM_SRC | Priority per source, smaller is more urgent |
| dom_en_i | input | 1 | Domain delivery enable |
| en_set_vld_i | input | 1 | Set-enable strobe |
| en_set_id_i | input | 10 | Source number for set-enable |
| en_clr_vld_i | input | 1 | Clear-enable strobe |
| en_clr_id_i | input | 10 | Source number for clear-enable |
| pend_clr_vld_i | input | 1 | Clear-pending strobe |
| pend_clr_id_i | input | 10 | Source number for clear-pending |
| claim_rd_i | input | 1 | Claim read strobe |
| topi_o | output | 32 | Top-interrupt word |
| claim_o | output | 32 | Claim word, equal to topi_o |
| irq_o | output | 1 | Interrupt line to the hart |

## Verification
The main stimulus counts through all 256 raw wire patterns of a mixed eight-source configuration. It interleaves claims, clear-pending writes and domain-enable gaps, so that level following, edge latching, inversion and priority ties are checked against a bench model on every pattern. Directed sequences then replay the mask, drop and unmask order. They separate a live pending bit from a latched one. Further sequences put a claim on a level source next to a claim on an edge source, and a clear-pending write in the same cycle as a new edge, which shows which of the two wins. Enable writes to off, detached, zero and out-of-range source numbers are checked to leave the top-interrupt word unchanged.

// File: rtl/dd_irq_pkg.sv
package dd_irq_pkg;
  localparam int unsigned ID_W   = 10;
  localparam int unsigned PRIO_W = 8;
  localparam int unsigned MODE_W = 3;

  typedef enum logic [MODE_W-1:0] {
    SM_OFF    = 3'd0,
    SM_DETACH = 3'd1,
    SM_RISE   = 3'd4,
    SM_FALL   = 3'd5,
    SM_HIGH   = 3'd6,
    SM_LOW    = 3'd7
  } src_mode_e;

  function automatic logic mode_live(input logic [MODE_W-1:0] m);
    return m[2];
  endfunction

  function automatic logic mode_level(input logic [MODE_W-1:0] m);
    return m[2] & m[1];
  endfunction

  function automatic logic mode_inv(input logic [MODE_W-1:0] m);
    return m[0];
  endfunction
endpackage

// File: rtl/dd_irq_src.sv
module dd_irq_src
  import dd_irq_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              raw_i,
  input  logic [MODE_W-1:0] mode_i,
  input  logic              en_set_i,
  input  logic              en_clr_i,
  input  logic              pend_clr_i,
  input  logic              claim_i,
  output logic              pend_o,
  output logic              en_o
);
  logic raw_q;
  logic rect, rect_prev, edge_hit;
  logic live, level;

  assign live      = mode_live(mode_i);
  assign level     = mode_level(mode_i);
  assign rect      = raw_i ^ mode_inv(mode_i);
  assign rect_prev = raw_q ^ mode_inv(mode_i);
  assign edge_hit  = rect & ~rect_prev;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      raw_q  <= 1'b0;
      pend_o <= 1'b0;
      en_o   <= 1'b0;
    end else begin
      raw_q <= raw_i;
      if (!live) begin
        pend_o <= 1'b0;
        en_o   <= 1'b0;
      end else begin
        if (en_clr_i)      en_o <= 1'b0;
        else if (en_set_i) en_o <= 1'b1;
        // level: live copy of rectified wire, never latched
        if (level)                      pend_o <= rect;
        else if (edge_hit)              pend_o <= 1'b1;
        else if (pend_clr_i || claim_i) pend_o <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/dd_irq_arb.sv
module dd_irq_arb
  import dd_irq_pkg::*;
#(
  parameter int unsigned NUM_SRC = 8
) (
  input  logic [NUM_SRC-1:0]        req_i,
  input  logic [PRIO_W*NUM_SRC-1:0] prio_i,
  output logic                      vld_o,
  output logic [ID_W-1:0]           id_o,
  output logic [PRIO_W-1:0]         prio_o
);
  always_comb begin
    vld_o  = 1'b0;
    id_o   = '0;
    prio_o = '0;
    // ascending scan with strict compare keeps the lower number on ties
    for (int i = 0; i < int'(NUM_SRC); i++) begin
      if (req_i[i] && (!vld_o || (prio_i[i*PRIO_W +: PRIO_W] < prio_o))) begin
        vld_o  = 1'b1;
        id_o   = ID_W'(i + 1);
        prio_o = prio_i[i*PRIO_W +: PRIO_W];
      end
    end
  end
endmodule

// File: rtl/dd_irq_ctrl.sv
module dd_irq_ctrl
  import dd_irq_pkg::*;
#(
  parameter int unsigned NUM_SRC = 8
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic [NUM_SRC-1:0]        src_raw_i,
  input  logic [MODE_W*NUM_SRC-1:0] src_mode_i,
  input  logic [PRIO_W*NUM_SRC-1:0] src_prio_i,
  input  logic                      dom_en_i,
  input  logic                      en_set_vld_i,
  input  logic [ID_W-1:0]           en_set_id_i,
  input  logic                      en_clr_vld_i,
  input  logic [ID_W-1:0]           en_clr_id_i,
  input  logic                      pend_clr_vld_i,
  input  logic [ID_W-1:0]           pend_clr_id_i,
  input  logic                      claim_rd_i,
  output logic [31:0]               topi_o,
  output logic [31:0]               claim_o,
  output logic                      irq_o
);
  logic [NUM_SRC-1:0] pend, en;
  logic               top_vld;
  logic [ID_W-1:0]    top_id;
  logic [PRIO_W-1:0]  top_prio;

  for (genvar k = 0; k < NUM_SRC; k++) begin : g_src
    logic set_hit, clr_hit, pclr_hit, claim_hit;
    assign set_hit   = en_set_vld_i   && (en_set_id_i   == ID_W'(k + 1));
    assign clr_hit   = en_clr_vld_i   && (en_clr_id_i   == ID_W'(k + 1));
    assign pclr_hit  = pend_clr_vld_i && (pend_clr_id_i == ID_W'(k + 1));
    assign claim_hit = claim_rd_i && top_vld && (top_id == ID_W'(k + 1));

    dd_irq_src i_src (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .raw_i      (src_raw_i[k]),
      .mode_i     (src_mode_i[k*MODE_W +: MODE_W]),
      .en_set_i   (set_hit),
      .en_clr_i   (clr_hit),
      .pend_clr_i (pclr_hit),
      .claim_i    (claim_hit),
      .pend_o     (pend[k]),
      .en_o       (en[k])
    );
  end

  dd_irq_arb #(.NUM_SRC(NUM_SRC)) i_arb (
    .req_i  (pend & en),
    .prio_i (src_prio_i),
    .vld_o  (top_vld),
    .id_o   (top_id),
    .prio_o (top_prio)
  );

  assign topi_o  = top_vld ? {6'd0, top_id, 8'd0, top_prio} : 32'd0;
  assign claim_o = topi_o;
  assign irq_o   = dom_en_i && top_vld;
endmodule

module dd_irq_ctrl_chk
  import dd_irq_pkg::*;
#(
  parameter int unsigned NUM_SRC = 8
) (
  input logic                      clk_i,
  input logic                      rst_ni,
  input logic [NUM_SRC-1:0]        src_raw_i,
  input logic [MODE_W*NUM_SRC-1:0] src_mode_i,
  input logic                      en_set_vld_i,
  input logic [ID_W-1:0]           en_set_id_i,
  input logic                      en_clr_vld_i,
  input logic [ID_W-1:0]           en_clr_id_i,
  input logic [NUM_SRC-1:0]        pend,
  input logic [NUM_SRC-1:0]        en,
  input logic [31:0]               topi_o
);
  logic up_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) up_q <= 1'b0;
    else         up_q <= 1'b1;
  end

  a_r4_none_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((pend & en) == '0) |-> (topi_o == 32'd0));

  for (genvar k = 0; k < NUM_SRC; k++) begin : g_chk
    logic [MODE_W-1:0] m;
    assign m = src_mode_i[k*MODE_W +: MODE_W];

    a_r1_level_follows: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (up_q && m[2] && m[1] && $stable(m)) |-> (pend[k] == ($past(src_raw_i[k]) ^ m[0])));

    a_r7_off_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (up_q && !m[2] && $stable(m)) |-> (!pend[k] && !en[k]));

    a_r3_clr_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (en_clr_vld_i && en_clr_id_i == ID_W'(k + 1)) |=> !en[k]);

    a_r3_set_en: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (en_set_vld_i && en_set_id_i == ID_W'(k + 1) && m[2] &&
       !(en_clr_vld_i && en_clr_id_i == ID_W'(k + 1))) |=> en[k]);

    a_r4_top_backed: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (topi_o[25:16] == ID_W'(k + 1)) |-> (pend[k] && en[k]));
  end
endmodule

bind dd_irq_ctrl dd_irq_ctrl_chk #(.NUM_SRC(NUM_SRC)) i_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .src_raw_i    (src_raw_i),
  .src_mode_i   (src_mode_i),
  .en_set_vld_i (en_set_vld_i),
  .en_set_id_i  (en_set_id_i),
  .en_clr_vld_i (en_clr_vld_i),
  .en_clr_id_i  (en_clr_id_i),
  .pend         (pend),
  .en           (en),
  .topi_o       (topi_o)
);

// File: tb/test_dd_irq_ctrl.sv
module test_dd_irq_ctrl;
  localparam int CLK_P = 10;
  localparam int N = 8;
  // src8..src1: high, detach, off, high, fall, rise, low, high
  localparam logic [3*N-1:0] MODES = {3'd6, 3'd1, 3'd0, 3'd6, 3'd5, 3'd4, 3'd7, 3'd6};
  localparam logic [8*N-1:0] PRIOS = {8'd4, 8'd1, 8'd1, 8'd2, 8'd5, 8'd2, 8'd2, 8'd3};

  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic [N-1:0] raw = '0;
  logic dom_en = 1'b0;
  logic sv = 1'b0, cv = 1'b0, pv = 1'b0, claim = 1'b0;
  logic [9:0] sid = '0, cid = '0, pid = '0;
  logic [31:0] topi, claimw;
  logic irq;

  int n_run = 0, n_fail = 0;
  logic m_pend [N];
  logic m_en [N];
  logic m_prev [N];

  always #(CLK_P/2) clk_i = ~clk_i;

  dd_irq_ctrl #(.NUM_SRC(N)) i_dd_irq_ctrl (
    .clk_i(clk_i), .rst_ni(rst_ni), .src_raw_i(raw), .src_mode_i(MODES),
    .src_prio_i(PRIOS), .dom_en_i(dom_en),
    .en_set_vld_i(sv), .en_set_id_i(sid), .en_clr_vld_i(cv), .en_clr_id_i(cid),
    .pend_clr_vld_i(pv), .pend_clr_id_i(pid), .claim_rd_i(claim),
    .topi_o(topi), .claim_o(claimw), .irq_o(irq)
  );

  function automatic logic [31:0] exp_topi();
    logic [31:0] r = 32'd0;
    logic [7:0]  bp = 8'd0;
    for (int k = 0; k < N; k++) begin
      if (m_pend[k] && m_en[k] && (r == 32'd0 || PRIOS[8*k +: 8] < bp)) begin
        bp = PRIOS[8*k +: 8];
        r  = {6'd0, 10'(k + 1), 8'd0, bp};
      end
    end
    return r;
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic model_step();
    logic [31:0] t = exp_topi();
    for (int k = 0; k < N; k++) begin
      logic [2:0] m = MODES[3*k +: 3];
      logic rect = raw[k] ^ m[0];
      logic prv  = m_prev[k] ^ m[0];
      if (!m[2]) begin
        m_pend[k] = 1'b0;
        m_en[k]   = 1'b0;
      end else begin
        if (cv && cid == 10'(k + 1))      m_en[k] = 1'b0;
        else if (sv && sid == 10'(k + 1)) m_en[k] = 1'b1;
        if (m[1]) m_pend[k] = rect;
        else if (rect && !prv) m_pend[k] = 1'b1;
        else if ((pv && pid == 10'(k + 1)) || (claim && t[25:16] == 10'(k + 1)))
          m_pend[k] = 1'b0;
      end
      m_prev[k] = raw[k];
    end
  endtask

  task automatic tick(input string tag);
    if (claim) check({tag, " R5 claim word"}, claimw, exp_topi());
    model_step();
    @(posedge clk_i);
    #1;
    check({tag, " R4 topi"}, topi, exp_topi());
    check({tag, " R8 irq"}, {31'd0, irq}, {31'd0, dom_en && exp_topi() != 32'd0});
    sv = 1'b0; cv = 1'b0; pv = 1'b0; claim = 1'b0;
  endtask

  initial begin
    #(CLK_P * 150000);
    n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    for (int k = 0; k < N; k++) begin m_pend[k] = 0; m_en[k] = 0; m_prev[k] = 0; end
    raw = 8'h02;
    #(CLK_P*3 + 1);
    check("R4 reset topi", topi, 32'd0);
    check("R8 reset irq", {31'd0, irq}, 32'd0);
    rst_ni = 1'b1;
    dom_en = 1'b1;
    tick("R7 idle");
    // enables, including ignored numbers 0 and 9
    for (int k = 0; k <= N + 1; k++) begin
      sv = 1'b1; sid = 10'(k);
      tick("R3 enable");
    end
    // R7: off and detached sources never show
    raw = 8'h62;
    tick("R7 off wires"); tick("R7 off wires");
    check("R7 off hidden", topi, 32'd0);
    // near-exhaustive sweep of raw patterns
    for (int p = 0; p < 256; p++) begin
      raw    = 8'(p);
      dom_en = (p % 5) != 0;
      claim  = (p % 3) == 0;
      if (p % 7 == 0) begin pv = 1'b1; pid = (p % 2 == 0) ? 10'd3 : 10'd1; end
      tick("R1 R6 sweep");
    end
    dom_en = 1'b1;
    // quiet all sources: src2 high means inactive, flush edge pendings
    raw = 8'h0A;
    tick("R6 quiet");
    pv = 1'b1; pid = 10'd3; tick("R6 clr3");
    pv = 1'b1; pid = 10'd4; tick("R6 clr4");
    check("R6 cleared", topi, 32'd0);
    // R2 mask, drop, unmask
    raw = 8'h0B; tick("R2 raise");
    check("R1 level high", topi, 32'h0001_0003);
    cv = 1'b1; cid = 10'd1; tick("R2 mask");
    check("R3 masked", topi, 32'd0);
    raw = 8'h0A; tick("R2 drop");
    sv = 1'b1; sid = 10'd1; tick("R2 unmask");
    check("R2 no stale", topi, 32'd0);
    raw = 8'h0B; tick("R2 live");
    check("R2 live shows", topi, 32'h0001_0003);
    claim = 1'b1; tick("R5 level claim");
    check("R5 level kept", topi, 32'h0001_0003);
    pv = 1'b1; pid = 10'd1; tick("R6 level clr ignored");
    check("R6 level clr ignored", topi, 32'h0001_0003);
    // R1 active-low and R4 ties
    raw = 8'h09; tick("R1 low");
    check("R1 low active", topi, 32'h0002_0002);
    raw = 8'h19; tick("R4 tie");
    check("R4 tie low id", topi, 32'h0002_0002);
    raw = 8'h1B; tick("R4 tie2");
    check("R4 next", topi, 32'h0005_0002);
    // R6 edge latch, claim, same-cycle set over clear
    raw = 8'h1F; tick("R6 rise");
    check("R6 rise sets", topi, 32'h0003_0002);
    raw = 8'h1B; tick("R6 hold");
    check("R6 held", topi, 32'h0003_0002);
    claim = 1'b1; tick("R5 edge claim");
    check("R5 edge cleared", topi, 32'h0005_0002);
    raw = 8'h1F; pv = 1'b1; pid = 10'd3; tick("R6 set wins");
    check("R6 set wins", topi, 32'h0003_0002);
    // R3 set and clear same cycle
    sv = 1'b1; sid = 10'd3; cv = 1'b1; cid = 10'd3; tick("R3 both");
    check("R3 clear wins", topi, 32'h0005_0002);
    // R8 domain gate
    dom_en = 1'b0; tick("R8 gate");
    check("R8 gated", {31'd0, irq}, 32'd0);
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule